// File: doc/BRIEF.md
# Five-Channel Down-Counter Bank with Clear-on-Read Status

This peripheral contains five reloadable 8-bit down-counters, called channels 1, 4, 5, 6 and 7. They sit behind a synchronous byte-wide register bus. All five count on a shared tick, which is the peripheral clock divided by two. A single run bit gates that tick. When a channel passes its terminal count, it reloads from its own period register and sets a sticky completion flag.

One register at address 0xA0 acts differently for reads and for writes. A read returns the completion flags and clears them. A write loads the per-channel interrupt enables and the run bit. The single interrupt line is high while any completion flag with its enable set is pending. A service routine reads 0xA0 once and then handles every flag it sees. A channel that completes in the same cycle as that read keeps its flag, and the next read returns it.

Top module: `tmr_bank`

## Requirements
- R1: After reset, `irq` and `bus_rdata` are 0. All completion flags and interrupt enables are clear, the run bit is 0, and every counter and period register holds 0.
- R2: A read strobe at address 0xA0 puts a status byte on `bus_rdata` in the cycle after the strobe is sampled. Bit 1 is the flag of channel 1 and bits 4, 5, 6 and 7 are the flags of channels 4, 5, 6 and 7. Bits 0, 2 and 3 read as 0. A read of any other address returns 0.
- R3: A status read clears every flag it returned.
- R4: A flag that sets on the same clock edge as a status read is not returned by that read. It stays set afterwards, so the next read returns it.
- R5: A completion flag stays set until a status read clears it.
- R6: A write to 0xA0 sets the interrupt enable of each channel from write-data bits 1, 4, 5, 6 and 7, matching the status bit positions. Write-data bit 0 sets the run bit.
- R7: While the run bit is 0, no channel counts and no flag sets.
- R8: While the run bit is 1, the shared tick occurs on every second clock. The first counting edge is the second clock edge after the edge that wrote the run bit to 1.
- R9: The period registers are write-only, at 0xA3 (channel 1), 0xA9 (channel 4), 0xAB (channel 5), 0xAD (channel 6) and 0xAF (channel 7). On a tick, a counter at 0 reloads its period value P and sets its flag. Otherwise the counter decrements. A running channel therefore completes every 2*(P+1) clocks.
- R10: `irq` is 1 exactly while some flag and its enable are both set. A read that clears the flags drops `irq` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after `bus_re` |
| irq | output | 1 | Combined interrupt request |

## Verification
Read data and flag clearing take effect on the edge that samples the read strobe. The bench therefore samples `bus_rdata` and `irq` on the falling edge right after that edge. A run-bit write produces its first flag two edges later, and the bench checks `irq` after one edge (expecting 0) and after two edges (expecting 1). Completion periods are measured between `irq` rises with a free-running edge counter and compared against 2*(P+1). The same counter is used to aim a status read at the exact edge where channel 1 completes, which checks that the flag is not lost.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH   = 5;
  localparam int BUS_W    = 8;
  localparam int ADDR_W   = 8;
  localparam logic [ADDR_W-1:0] CSR_ADDR = 8'hA0;

  // status/enable bit position of channel index i (channels 1,4,5,6,7)
  function automatic int ch_bit(input int i);
    case (i)
      0:       return 1;
      1:       return 4;
      2:       return 5;
      3:       return 6;
      default: return 7;
    endcase
  endfunction

  // period register address of channel index i
  function automatic logic [ADDR_W-1:0] per_addr(input int i);
    case (i)
      0:       return 8'hA3;
      1:       return 8'hA9;
      2:       return 8'hAB;
      3:       return 8'hAD;
      default: return 8'hAF;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)   div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                  div_q <= div_q + 1'b1;
  end

  assign tick = run && (div_q == LAST);
endmodule

// File: rtl/tmr_down.sv
module tmr_down #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             per_we,
  input  logic [CNT_W-1:0] per_wdata,
  output logic             done
);
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign done    = tick && at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n)      per_q <= '0;
    else if (per_we) per_q <= per_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick) begin
      if (at_zero)    cnt_q <= per_q;
      else            cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tmr_csr.sv
module tmr_csr
  import tmr_pkg::*;
#(
  parameter int N = NUM_CH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_hit,
  input  logic             wr_hit,
  input  logic [N-1:0]     ie_wdata,
  input  logic             run_wdata,
  input  logic [N-1:0]     done,
  output logic             run,
  output logic [N-1:0]     ie,
  output logic [N-1:0]     flags,
  output logic [BUS_W-1:0] rdata,
  output logic             irq
);
  logic [BUS_W-1:0] status;
  logic [N-1:0]     kept;

  always_comb begin
    status = '0;
    for (int i = 0; i < N; i++) status[ch_bit(i)] = flags[i];
  end

  // a read clears what it returned; flags arriving on that edge still land
  assign kept = rd_hit ? '0 : flags;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= kept | done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie  <= '0;
      run <= 1'b0;
    end else if (wr_hit) begin
      ie  <= ie_wdata;
      run <= run_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_hit ? status : '0;
  end

  assign irq = |(flags & ie);
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  logic              rd_hit, wr_hit;
  logic              run, tick;
  logic [NUM_CH-1:0] ie_wdata, ie, flags, done;

  assign rd_hit = bus_re && (bus_addr == CSR_ADDR);
  assign wr_hit = bus_we && (bus_addr == CSR_ADDR);

  tmr_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic per_we;
    assign per_we      = bus_we && (bus_addr == per_addr(g));
    assign ie_wdata[g] = bus_wdata[ch_bit(g)];
    tmr_down #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .per_we(per_we),
      .per_wdata(bus_wdata[CNT_W-1:0]), .done(done[g])
    );
  end

  tmr_csr #(.N(NUM_CH)) u_csr (
    .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .wr_hit(wr_hit),
    .ie_wdata(ie_wdata), .run_wdata(bus_wdata[0]), .done(done),
    .run(run), .ie(ie), .flags(flags), .rdata(bus_rdata), .irq(irq)
  );
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rd_hit,
  input logic         run,
  input logic         tick,
  input logic [N-1:0] done,
  input logic [N-1:0] flags,
  input logic [7:0]   rdata,
  input logic         irq
);
  // R2: unused status positions always read as zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[0] == 1'b0) && (rdata[3:2] == 2'b00));

  // R3: a read with no completion on that edge leaves no flag set
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && done == '0) |=> (flags == '0));

  // R4: a completion is never dropped, even on a read edge
  a_r4_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |=> ((flags & $past(done)) == $past(done)));

  // R5: flags hold until read
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> ((flags & $past(flags)) == $past(flags)));

  // R7: no tick while stopped
  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

  // R8: ticks never on adjacent clocks
  a_r8_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R10: request drops after a clearing read
  a_r10_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && done == '0) |=> !irq);
endmodule

bind tmr_bank tmr_bank_chk #(.N(tmr_pkg::NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .run(run), .tick(tick),
  .done(done), .flags(flags), .rdata(bus_rdata), .irq(irq)
);

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] rdata;
  logic       irq;
  int         cyc = 0;
  int         n_chk = 0, n_fail = 0;
  bit         ended = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_re(re), .bus_rdata(rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; re = 1'b1;
    @(posedge clk); @(negedge clk);
    re = 1'b0; d = rdata;
  endtask

  task automatic wait_irq(output int t);
    int n = 0;
    while (!irq && n < 2000) begin
      @(posedge clk); @(negedge clk); n++;
    end
    t = cyc;
    check(irq, "R10 irq rise", irq, 1);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(rdata == 8'h00, "R1 rdata", rdata, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    rd(8'hA0, d);
    check(d == 8'h00, "R1 flags", d, 0);
  endtask

  task automatic t_stopped();
    logic [7:0] d;
    wr(8'hA3, 8'd200); wr(8'hA9, 8'd200); wr(8'hAB, 8'd200);
    wr(8'hAD, 8'd200); wr(8'hAF, 8'd200);
    repeat (20) @(negedge clk);
    rd(8'hA0, d);
    check(d == 8'h00, "R7 no count while stopped", d, 0);
  endtask

  task automatic t_first_and_period();
    logic [7:0] d;
    int t0, t1, tgt;
    wr(8'hA3, 8'd3);
    wr(8'hA0, 8'h03);                   // enable ch1 interrupt and run
    check(irq == 1'b0, "R8 no flag at write edge", irq, 0);
    @(posedge clk); @(negedge clk);
    check(irq == 1'b0, "R8 no flag one edge later", irq, 0);
    @(posedge clk); @(negedge clk);
    check(irq == 1'b1, "R8 first tick two edges later", irq, 1);
    t0 = cyc;
    rd(8'hA0, d);
    check(d == 8'hF2, "R2 all channels at zero complete", d, 8'hF2);
    check(irq == 1'b0, "R10 irq dropped by read", irq, 0);
    rd(8'hA0, d);
    check(d == 8'h00, "R3 flags cleared", d, 0);
    wait_irq(t1);
    check((t1 - t0) == 8, "R9 period P=3", t1 - t0, 8);
    rd(8'hA0, d);
    check(d == 8'h02, "R2 ch1 at bit 1", d, 8'h02);
    tgt = t1 + 7;
    while (cyc != tgt) @(negedge clk);
    rd(8'hA0, d);                       // edge coincides with next completion
    check(d == 8'h00, "R4 same-edge flag not returned", d, 0);
    check(irq == 1'b1, "R4 same-edge flag kept", irq, 1);
    rd(8'hA0, d);
    check(d == 8'h02, "R4 kept flag read next", d, 8'h02);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(8'hA0, 8'h01);                   // run, no enables
    repeat (20) @(negedge clk);
    check(irq == 1'b0, "R10 masked", irq, 0);
    rd(8'hA0, d);
    check((d & 8'h02) != 0, "R5 flag sticky", d, 8'h02);
  endtask

  task automatic t_ch4_period();
    logic [7:0] d;
    int t0, t1;
    wr(8'hA9, 8'd5);
    wr(8'hA0, 8'h11);                   // ch4 enable, run
    rd(8'hA0, d);
    wait_irq(t0);
    rd(8'hA0, d);
    check((d & 8'h10) != 0, "R6 ch4 flag at bit 4", d, 8'h10);
    wait_irq(t1);
    check((t1 - t0) == 12, "R9 period P=5", t1 - t0, 12);
  endtask

  task automatic t_stop_and_other();
    logic [7:0] d;
    wr(8'hA0, 8'h12);                   // stop, enables on
    rd(8'hA0, d);
    repeat (40) @(negedge clk);
    check(irq == 1'b0, "R7 stopped irq", irq, 0);
    rd(8'hA0, d);
    check(d == 8'h00, "R7 stopped flags", d, 0);
    rd(8'hA3, d);
    check(d == 8'h00, "R9 period reg write-only", d, 0);
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stopped();
    t_first_and_period();
    t_mask();
    t_ch4_period();
    t_stop_and_other();
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule